// File: doc/BRIEF.md
# Keypress Serial Readout Port

This block connects a keypad encoder to a host that reads it over a three-wire serial link. The encoder signals a new key with a data-available strobe and presents a 4-bit key code. When the strobe rises, the port arms itself and loads an 8-bit shift register with the code and a set key-ready flag. The flag is the first bit the host sees, so a single clocked-in bit is enough to poll for a key.

The host pulls the active-low chip select low and toggles the serial clock. On each falling serial-clock edge the register moves one place toward its output end. The host samples the output on the rising edge. The serial data input enters at the far end of the register, so several ports or other devices can be chained behind one another. While the port is armed it ignores new strobes. Releasing chip select disarms the port so it can take the next key. An interrupt request output follows the arm flip-flop, or the synchronized strobe if the block is configured that way. All asynchronous inputs pass through synchronizers into the system clock domain.

Top module: `keypad_serial_port`

## Requirements
- R1: A rising edge of `key_avail` (seen after synchronization) while the port is disarmed loads the shift register and arms the port, with a one-system-clock load pulse.
- R2: The loaded word has bit 7 = 1 (key-ready flag), bits 6..4 = 0 and bits 3..0 = `key_code`, and `ser_out` presents bit 7 right after the load.
- R3: The register shifts only while `sel_n` is low, one place toward bit 7 per falling edge of `ser_clk`, so bits leave MSB first. `ser_clk` activity while `sel_n` is high changes nothing.
- R4: On each shift the synchronized value of `ser_in` enters bit 0. After 8 shifts with `ser_in` low the ready flag is gone and `ser_out` reads 0. Other `ser_in` bits reappear at `ser_out` 8 shifts later, in order.
- R5: While the port is armed, further `key_avail` rising edges do not reload the register.
- R6: A rising edge of `sel_n` disarms the port, and the next `key_avail` rising edge loads a new key.
- R7: A `key_avail` rising edge in the same cycle as a `sel_n` rising edge is accepted: the register loads and the port stays armed.
- R8: With `IRQ_FROM_ARM` = 1 (default), `irq` is high exactly while the port is armed, from the load until chip-select release.
- R9: After reset the register is zero, the port is disarmed, and `ser_out` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_avail | input | 1 | Data-available strobe from the encoder (asynchronous) |
| key_code | input | CODE_W | Key code, stable while `key_avail` is high |
| sel_n | input | 1 | Active-low chip select from the host (asynchronous) |
| ser_clk | input | 1 | Serial clock from the host, idle low (asynchronous) |
| ser_in | input | 1 | Serial data input for chaining |
| ser_out | output | 1 | Serial data output, bit 7 of the register |
| irq | output | 1 | Interrupt request |

## Verification
Two things can happen in the same system clock: a new key strobe, and the chip-select release that ends the previous read. The bench provokes this by driving `key_avail` high and `sel_n` high on the same clock edge, after a partial read of an armed port. Both signals pass through equal synchronizer depths, so both edges are detected in one cycle. The result is judged at the ports: `ser_out` must show the fresh ready flag, `irq` must stay high, and a following read must return the new code rather than the residue of the old word.

// File: rtl/kp_pkg.sv
package kp_pkg;
   // Build the parallel-load word: flag at the top, code at the bottom, zeros between.
   function automatic logic [7:0] kp_word8(input logic [3:0] code);
      return {1'b1, 3'b000, code};
   endfunction
endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("kp_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/kp_arm.sv
module kp_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic avail_s,
   input  logic sel_n_s,
   output logic load_o,
   output logic armed_o
);
   logic avail_q, sel_q;
   logic avail_rise, sel_rise, take;

   assign avail_rise = avail_s & ~avail_q;
   assign sel_rise   = sel_n_s & ~sel_q;
   // A release in the same cycle frees the port for the incoming key.
   assign take       = avail_rise & (~armed_o | sel_rise);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         avail_q <= 1'b0;
         sel_q   <= 1'b1;
         load_o  <= 1'b0;
         armed_o <= 1'b0;
      end else begin
         avail_q <= avail_s;
         sel_q   <= sel_n_s;
         load_o  <= take;
         if (take)          armed_o <= 1'b1;
         else if (sel_rise) armed_o <= 1'b0;
      end
   end

   p_no_reload_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_o && !sel_rise) |=> !load_o);
   p_release_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_rise && !avail_rise) |=> !armed_o);
   p_coincide_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_rise && avail_rise) |=> (load_o && armed_o));
   p_pulse_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      load_o |=> !load_o);
endmodule

// File: rtl/kp_shift.sv
module kp_shift #(
   parameter int CODE_W = 4,
   parameter int REG_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              sel_n_s,
   input  logic              sclk_s,
   input  logic              sin_s,
   output logic              sout_o
);
   localparam int PAD_W = REG_W - CODE_W - 1;

   if (PAD_W < 0) begin : g_bad_width
      $error("kp_shift: REG_W must exceed CODE_W");
   end

   logic [REG_W-1:0] sreg, load_word;
   logic             sclk_q, fall;

   if (PAD_W > 0) begin : g_pad
      assign load_word = {1'b1, {PAD_W{1'b0}}, code_i};
   end else begin : g_nopad
      assign load_word = {1'b1, code_i};
   end

   assign fall = sclk_q & ~sclk_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg   <= '0;
         sclk_q <= 1'b0;
      end else begin
         sclk_q <= sclk_s;
         if (load_i)                sreg <= load_word;
         else if (fall && !sel_n_s) sreg <= {sreg[REG_W-2:0], sin_s};
      end
   end

   assign sout_o = sreg[REG_W-1];

   p_load_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (sreg[REG_W-1] && sreg[CODE_W-1:0] == $past(code_i)));
   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n_s && !load_i) |=> $stable(sreg));
   p_shift_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !sel_n_s && !load_i) |=>
         (sreg[0] == $past(sin_s) && sreg[REG_W-1:1] == $past(sreg[REG_W-2:0])));
endmodule

// File: rtl/keypad_serial_port.sv
module keypad_serial_port #(
   parameter int CODE_W       = 4,
   parameter int REG_W        = 8,
   parameter int SYNC_STAGES  = 2,
   parameter bit IRQ_FROM_ARM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_avail,
   input  logic [CODE_W-1:0] key_code,
   input  logic              sel_n,
   input  logic              ser_clk,
   input  logic              ser_in,
   output logic              ser_out,
   output logic              irq
);
   logic avail_s, sel_n_s, sclk_s, sin_s;
   logic load, armed;

   kp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_avail
      (.clk(clk), .rst_n(rst_n), .d(key_avail), .q(avail_s));
   kp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel
      (.clk(clk), .rst_n(rst_n), .d(sel_n), .q(sel_n_s));
   kp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk
      (.clk(clk), .rst_n(rst_n), .d(ser_clk), .q(sclk_s));
   kp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sin
      (.clk(clk), .rst_n(rst_n), .d(ser_in), .q(sin_s));

   kp_arm u_arm (
      .clk(clk), .rst_n(rst_n), .avail_s(avail_s), .sel_n_s(sel_n_s),
      .load_o(load), .armed_o(armed)
   );

   kp_shift #(.CODE_W(CODE_W), .REG_W(REG_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load_i(load), .code_i(key_code),
      .sel_n_s(sel_n_s), .sclk_s(sclk_s), .sin_s(sin_s), .sout_o(ser_out)
   );

   if (IRQ_FROM_ARM) begin : g_irq_arm
      assign irq = armed;
      p_irq_on_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
         load |=> irq);
   end else begin : g_irq_avail
      assign irq = avail_s;
   end
endmodule

// File: tb/tb_keypad_serial_port.sv
module tb_keypad_serial_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       key_avail = 1'b0;
   logic [3:0] key_code = 4'h0;
   logic       sel_n = 1'b1;
   logic       ser_clk = 1'b0;
   logic       ser_in = 1'b0;
   logic       ser_out, irq;

   int vectors = 0;
   int errors  = 0;
   logic [7:0] m_reg   = 8'h00;
   logic       m_armed = 1'b0;

   always #2 clk = ~clk;

   keypad_serial_port dut (
      .clk(clk), .rst_n(rst_n), .key_avail(key_avail), .key_code(key_code),
      .sel_n(sel_n), .ser_clk(ser_clk), .ser_in(ser_in),
      .ser_out(ser_out), .irq(irq)
   );

   function automatic logic [7:0] load_word(input logic [3:0] c);
      return {1'b1, 3'b000, c};
   endfunction

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_ports(input string req);
      check(req, ser_out, m_reg[7]);
      check(req, irq, m_armed);
   endtask

   task automatic press(input logic [3:0] c);
      key_code = c;
      key_avail = 1'b1;
      settle();
      if (!m_armed) begin m_reg = load_word(c); m_armed = 1'b1; end
      key_avail = 1'b0;
      settle();
   endtask

   task automatic shift_bit(input logic din, input string req);
      ser_in = din;
      ser_clk = 1'b1;
      settle();
      check(req, ser_out, m_reg[7]);
      ser_clk = 1'b0;
      settle();
      m_reg = {m_reg[6:0], din};
   endtask

   task automatic release_sel();
      sel_n = 1'b1;
      settle();
      m_armed = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9", ser_out, 1'b0);
      check("R9", irq, 1'b0);
      rst_n = 1'b1;
      settle();
      check_ports("R9");

      // R1 R2 R8: first key loads flag and code, irq follows arm
      press(4'hA);
      check("R2", ser_out, 1'b1);
      check("R8", irq, 1'b1);

      // R3: clocks with chip select high are ignored
      ser_clk = 1'b1; settle(); ser_clk = 1'b0; settle();
      check_ports("R3");

      // R3 R4: read out all 8 bits MSB first with zero fill
      sel_n = 1'b0; settle();
      for (int i = 0; i < 8; i++) shift_bit(1'b0, "R3");
      check("R4", ser_out, 1'b0);

      // R5: strobe while armed does not reload
      press(4'h5);
      check("R5", ser_out, 1'b0);
      check("R5", irq, 1'b1);

      // R6: release disarms; next key loads
      release_sel();
      check("R6", irq, 1'b0);
      press(4'h6);
      check("R6", ser_out, 1'b1);
      check("R6", irq, 1'b1);

      // R4: chained bits come back out after 8 shifts
      sel_n = 1'b0; settle();
      for (int i = 0; i < 8; i++) shift_bit((i % 3) == 0, "R4");
      for (int i = 0; i < 8; i++) shift_bit(1'b0, "R4");
      release_sel();
      check_ports("R6");

      // R7: key strobe coincides with chip-select release
      press(4'h3);
      sel_n = 1'b0; settle();
      shift_bit(1'b0, "R7"); shift_bit(1'b0, "R7");
      key_code = 4'hC;
      sel_n = 1'b1; key_avail = 1'b1;
      settle();
      m_reg = load_word(4'hC); m_armed = 1'b1;
      check("R7", ser_out, 1'b1);
      check("R7", irq, 1'b1);
      key_avail = 1'b0; settle();
      sel_n = 1'b0; settle();
      for (int i = 0; i < 8; i++) shift_bit(1'b0, "R7");
      release_sel();

      // Random mix of key presses, reads and stray clocks (R1-style flows)
      for (int n = 0; n < 120; n++) begin
         int op;
         op = $urandom_range(0, 2);
         if (op == 0) begin
            press(4'($urandom_range(0, 15)));
            check_ports("R5");
         end else if (op == 1) begin
            int k;
            k = $urandom_range(0, 10);
            sel_n = 1'b0; settle();
            for (int i = 0; i < k; i++) shift_bit(1'($urandom_range(0, 1)), "R4");
            release_sel();
            check_ports("R6");
         end else begin
            ser_in = 1'($urandom_range(0, 1));
            ser_clk = 1'b1; settle(); ser_clk = 1'b0; settle();
            check_ports("R3");
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule